// File: doc/BRIEF.md
# Accumulator ALU with Packed Flag Register

This block is the 8-bit arithmetic and logic stage of a small accumulator machine. It holds the accumulator and four condition flags (zero, subtract, half-carry, carry) in registers. Each cycle in which `opValid` is high, it applies the operation selected by `opCode` to the accumulator, the 8-bit `operand` and the stored flags. It then writes back a new accumulator and a new set of flags at the next rising clock edge.

The arithmetic group adds or subtracts, with or without the stored carry. Compare runs the subtraction but keeps the accumulator. The logic group performs AND, XOR and OR. The accumulator-only operations complement the accumulator, complement or set the carry, and apply the decimal correction that turns the result of a packed-BCD add or subtract back into valid BCD. Two load operations let the surrounding machine place a value in the accumulator or in the flag byte. The flags are always presented as a packed byte whose low nibble is zero.

Top module: `acc_flag_alu`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first operation, `accOut` is 0x00 and `flagsOut` is 0x00.
- R2: ADD writes A+operand and ADC writes A+operand+C into the accumulator, both modulo 256. C is the carry out of bit 7, H is the carry out of bit 3, N is cleared and Z is set when the 8-bit result is zero.
- R3: SUB writes A−operand and SBC writes A−operand−C, both modulo 256. C is set on a borrow from bit 8, H is set on a borrow from bit 4, N is set and Z is set when the 8-bit result is zero.
- R4: CP sets Z, N, H and C exactly as SUB would for the same inputs, and leaves the accumulator unchanged.
- R5: AND, XOR and OR write the bitwise result into the accumulator. Z follows the result, N and C are cleared, and H is set by AND and cleared by XOR and OR.
- R6: CPL replaces the accumulator with its bitwise complement and sets N and H. Z and C are unchanged.
- R7: SCF sets C, CCF inverts C, and both clear N and H. Z and the accumulator are unchanged.
- R8: DAA corrects the accumulator after an addition (N=0) or a subtraction (N=1) of packed BCD values. The result is the BCD value of the decimal sum or difference modulo 100. C is set after an addition whose decimal sum is 100 or more, and C is kept as the borrow after a subtraction. H is cleared, N is kept, and Z follows the result.
- R9: `flagsOut` carries Z in bit 7, N in bit 6, H in bit 5 and C in bit 4, and bits 3..0 always read 0. Load-flags takes Z, N, H and C from `operand` bits 7..4 and ignores `operand` bits 3..0.
- R10: Load-accumulator copies `operand` into the accumulator and leaves all flags unchanged.
- R11: The result of an operation presented with `opValid` high on a rising clock edge appears on `accOut`/`flagsOut` after that edge. When `opValid` is low, or `opCode` is 14 or 15, neither output changes.
- R12: The `opCode` encoding is: 0 ADD, 1 ADC, 2 SUB, 3 SBC, 4 AND, 5 XOR, 6 OR, 7 CP, 8 CPL, 9 CCF, 10 SCF, 11 DAA, 12 load-accumulator, 13 load-flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Apply `opCode` on this clock edge |
| opCode | input | 4 | Operation select (encoding in R12) |
| operand | input | 8 | Second operand, load value or flag image |
| accOut | output | 8 | Current accumulator |
| flagsOut | output | 8 | Packed flag byte {Z,N,H,C,0000} |

## Verification
The bench targets the half-carry and borrow boundaries at bit 3/4 and the wrap at bit 7/8. A design that taps the wrong carry would report H or C on the wrong inputs. It also checks that the carry-in is used by ADC and SBC and ignored by ADD and SUB. Compare is run with equal and with larger operands, which catches a design that writes the difference back or forgets to set N. The decimal correction is swept over many BCD pairs in both directions, including sums that cross 99 and differences that go negative. A design that reads the wrong nibble, ignores H, or takes the direction from anything other than the stored N would produce wrong BCD digits or a wrong carry. The loads confirm the ignored low nibble of the flag byte, and idle cycles and the unused opcodes must leave both outputs untouched.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  localparam int DATA_W   = 8;
  localparam int NIB_W    = 4;
  localparam int NIBBLES  = DATA_W / NIB_W;
  localparam int OPC_W    = 4;
  localparam int FLAG_CNT = 4;
  localparam int PAD_W    = DATA_W - FLAG_CNT;

  // BCD correction constants and limits
  localparam logic [DATA_W-1:0] LOW_FIX   = 8'h06;
  localparam logic [DATA_W-1:0] HIGH_FIX  = 8'h60;
  localparam logic [DATA_W-1:0] BCD_MAX   = 8'h99;
  localparam logic [NIB_W-1:0]  DIGIT_MAX = 4'h9;

  typedef enum logic [OPC_W-1:0] {
    OP_ADD = 4'd0,
    OP_ADC = 4'd1,
    OP_SUB = 4'd2,
    OP_SBC = 4'd3,
    OP_AND = 4'd4,
    OP_XOR = 4'd5,
    OP_OR  = 4'd6,
    OP_CP  = 4'd7,
    OP_CPL = 4'd8,
    OP_CCF = 4'd9,
    OP_SCF = 4'd10,
    OP_DAA = 4'd11,
    OP_LDA = 4'd12,
    OP_LDF = 4'd13
  } opcode_e;

  typedef enum logic [2:0] {
    K_ARITH,
    K_LOGIC,
    K_CPL,
    K_CCF,
    K_SCF,
    K_DAA,
    K_LDA,
    K_LDF
  } kind_e;

  typedef enum logic [1:0] {
    L_AND,
    L_XOR,
    L_OR
  } logic_sel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       fire;
    kind_e      kind;
    logic       subtract;
    logic       withCarry;
    logic       storeAcc;
    logic_sel_e logicSel;
  } ctrl_t;

  typedef struct packed {
    logic z;
    logic n;
    logic h;
    logic c;
  } flag_t;

endpackage

// File: rtl/acc_alu_ctrl.sv
module acc_alu_ctrl
  import acc_alu_pkg::*;
(
  input  logic             opValid,
  input  logic [OPC_W-1:0] opCode,
  output ctrl_t            ctrl
);

  always_comb begin
    ctrl           = '0;
    ctrl.kind      = K_ARITH;
    ctrl.logicSel  = L_AND;
    ctrl.storeAcc  = 1'b1;
    ctrl.fire      = opValid;
    case (opCode)
      OP_ADD: ctrl.kind = K_ARITH;
      OP_ADC: begin ctrl.kind = K_ARITH; ctrl.withCarry = 1'b1; end
      OP_SUB: begin ctrl.kind = K_ARITH; ctrl.subtract  = 1'b1; end
      OP_SBC: begin
        ctrl.kind      = K_ARITH;
        ctrl.subtract  = 1'b1;
        ctrl.withCarry = 1'b1;
      end
      OP_CP: begin
        ctrl.kind     = K_ARITH;
        ctrl.subtract = 1'b1;
        ctrl.storeAcc = 1'b0;
      end
      OP_AND: begin ctrl.kind = K_LOGIC; ctrl.logicSel = L_AND; end
      OP_XOR: begin ctrl.kind = K_LOGIC; ctrl.logicSel = L_XOR; end
      OP_OR:  begin ctrl.kind = K_LOGIC; ctrl.logicSel = L_OR;  end
      OP_CPL: ctrl.kind = K_CPL;
      OP_CCF: ctrl.kind = K_CCF;
      OP_SCF: ctrl.kind = K_SCF;
      OP_DAA: ctrl.kind = K_DAA;
      OP_LDA: ctrl.kind = K_LDA;
      OP_LDF: ctrl.kind = K_LDF;
      default: ctrl.fire = 1'b0;
    endcase
  end

  // R11: unused codes never raise the fire strobe
  always_comb begin
    if (opCode > OPC_W'(OP_LDF)) begin
      a_unused_code_idle_r11 : assert (!ctrl.fire);
    end
  end

endmodule

// File: rtl/acc_alu_datapath.sv
module acc_alu_datapath
  import acc_alu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  ctrl_t             ctrl,
  input  logic [DATA_W-1:0] operand,
  output logic [DATA_W-1:0] accQ,
  output flag_t             flagQ
);

  // ---------------- adder / subtractor, nibble chained ----------------
  logic [DATA_W-1:0] addB;
  logic [DATA_W-1:0] arithRes;
  logic [NIBBLES:0]  nibCarry;
  logic              carryUse;
  logic              arithC;
  logic              arithH;

  assign addB        = ctrl.subtract ? ~operand : operand;
  assign carryUse    = ctrl.withCarry & flagQ.c;
  assign nibCarry[0] = ctrl.subtract ? ~carryUse : carryUse;

  for (genvar g = 0; g < NIBBLES; g++) begin : g_nib
    logic [NIB_W:0] nibSum;
    assign nibSum = {1'b0, accQ[g*NIB_W +: NIB_W]}
                  + {1'b0, addB[g*NIB_W +: NIB_W]}
                  + {{NIB_W{1'b0}}, nibCarry[g]};
    assign arithRes[g*NIB_W +: NIB_W] = nibSum[NIB_W-1:0];
    assign nibCarry[g+1]              = nibSum[NIB_W];
  end

  // in subtract mode a missing carry means a borrow
  assign arithC = nibCarry[NIBBLES] ^ ctrl.subtract;
  assign arithH = nibCarry[1] ^ ctrl.subtract;

  // ---------------- logic unit ----------------
  logic [DATA_W-1:0] logicRes;
  always_comb begin
    case (ctrl.logicSel)
      L_AND:   logicRes = accQ & operand;
      L_XOR:   logicRes = accQ ^ operand;
      default: logicRes = accQ | operand;
    endcase
  end

  // ---------------- decimal correction ----------------
  logic [DATA_W-1:0] daaFix;
  logic [DATA_W-1:0] daaRes;
  logic              daaC;
  always_comb begin
    daaFix = '0;
    daaC   = flagQ.c;
    if (!flagQ.n) begin
      if (flagQ.c || (accQ > BCD_MAX)) begin
        daaFix = daaFix | HIGH_FIX;
        daaC   = 1'b1;
      end
      if (flagQ.h || (accQ[NIB_W-1:0] > DIGIT_MAX)) begin
        daaFix = daaFix | LOW_FIX;
      end
      daaRes = accQ + daaFix;
    end else begin
      if (flagQ.c) daaFix = daaFix | HIGH_FIX;
      if (flagQ.h) daaFix = daaFix | LOW_FIX;
      daaRes = accQ - daaFix;
    end
  end

  // ---------------- next state selection ----------------
  logic [DATA_W-1:0] nextAcc;
  flag_t             nextFlag;
  always_comb begin
    nextAcc  = accQ;
    nextFlag = flagQ;
    case (ctrl.kind)
      K_ARITH: begin
        if (ctrl.storeAcc) nextAcc = arithRes;
        nextFlag.z = (arithRes == '0);
        nextFlag.n = ctrl.subtract;
        nextFlag.h = arithH;
        nextFlag.c = arithC;
      end
      K_LOGIC: begin
        nextAcc    = logicRes;
        nextFlag.z = (logicRes == '0);
        nextFlag.n = 1'b0;
        nextFlag.h = (ctrl.logicSel == L_AND);
        nextFlag.c = 1'b0;
      end
      K_CPL: begin
        nextAcc    = ~accQ;
        nextFlag.n = 1'b1;
        nextFlag.h = 1'b1;
      end
      K_CCF: begin
        nextFlag.n = 1'b0;
        nextFlag.h = 1'b0;
        nextFlag.c = ~flagQ.c;
      end
      K_SCF: begin
        nextFlag.n = 1'b0;
        nextFlag.h = 1'b0;
        nextFlag.c = 1'b1;
      end
      K_DAA: begin
        nextAcc    = daaRes;
        nextFlag.z = (daaRes == '0);
        nextFlag.h = 1'b0;
        nextFlag.c = daaC;
      end
      K_LDA: nextAcc = operand;
      default: nextFlag = flag_t'(operand[DATA_W-1 -: FLAG_CNT]);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      accQ  <= '0;
      flagQ <= '0;
    end else if (ctrl.fire) begin
      accQ  <= nextAcc;
      flagQ <= nextFlag;
    end
  end

  // ---------------- assertions ----------------
  p_add_clears_n_r2 : assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.fire && ctrl.kind == K_ARITH && !ctrl.subtract |=> !flagQ.n);

  p_sub_sets_n_r3 : assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.fire && ctrl.kind == K_ARITH && ctrl.subtract |=> flagQ.n);

  p_cp_holds_acc_r4 : assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.fire && ctrl.kind == K_ARITH && !ctrl.storeAcc |=> $stable(accQ));

  p_logic_clears_c_r5 : assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.fire && ctrl.kind == K_LOGIC |=> !flagQ.c && !flagQ.n);

  p_cpl_inverts_r6 : assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.fire && ctrl.kind == K_CPL |=> accQ == ~$past(accQ) && flagQ.n && flagQ.h);

  p_scf_sets_c_r7 : assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.fire && ctrl.kind == K_SCF |=> flagQ.c && !flagQ.n && !flagQ.h);

  p_ccf_flips_c_r7 : assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.fire && ctrl.kind == K_CCF |=> flagQ.c != $past(flagQ.c));

  p_daa_clears_h_r8 : assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.fire && ctrl.kind == K_DAA |=> !flagQ.h && $stable(flagQ.n));

  p_ldf_upper_r9 : assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.fire && ctrl.kind == K_LDF |=> flagQ == $past(operand[DATA_W-1 -: FLAG_CNT]));

  p_lda_keeps_flags_r10 : assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.fire && ctrl.kind == K_LDA |=> $stable(flagQ) && accQ == $past(operand));

  p_idle_hold_r11 : assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.fire |=> $stable(accQ) && $stable(flagQ));

endmodule

// File: rtl/acc_flag_alu.sv
module acc_flag_alu
  import acc_alu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              opValid,
  input  logic [OPC_W-1:0]  opCode,
  input  logic [DATA_W-1:0] operand,
  output logic [DATA_W-1:0] accOut,
  output logic [DATA_W-1:0] flagsOut
);

  ctrl_t ctrl;
  flag_t flagQ;

  acc_alu_ctrl u_ctrl (
    .opValid (opValid),
    .opCode  (opCode),
    .ctrl    (ctrl)
  );

  acc_alu_datapath u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctrl    (ctrl),
    .operand (operand),
    .accQ    (accOut),
    .flagQ   (flagQ)
  );

  assign flagsOut = {flagQ, {PAD_W{1'b0}}};

  // R1: reset clears both outputs on the following edge
  p_reset_clear_r1 : assert property (@(posedge clk)
    !rst_n |=> accOut == '0 && flagsOut == '0);

endmodule

// File: tb/acc_flag_alu_bench.sv
`timescale 1ns/1ps
module acc_flag_alu_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       opValid = 1'b0;
  logic [3:0] opCode = 4'd0;
  logic [7:0] operand = 8'd0;
  logic [7:0] accOut;
  logic [7:0] flagsOut;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  acc_flag_alu u_acc_flag_alu (
    .clk(clk), .rst_n(rst_n), .opValid(opValid), .opCode(opCode),
    .operand(operand), .accOut(accOut), .flagsOut(flagsOut)
  );

  localparam logic [3:0] C_ADD = 0, C_ADC = 1, C_SUB = 2, C_SBC = 3,
    C_AND = 4, C_XOR = 5, C_OR = 6, C_CP = 7, C_CPL = 8, C_CCF = 9,
    C_SCF = 10, C_DAA = 11, C_LDA = 12, C_LDF = 13;

  task automatic check(input string tag, input logic [7:0] expA, input logic [7:0] expF);
    checks++;
    if (accOut !== expA || flagsOut !== expF) begin
      errors++;
      $display("FAIL %s: acc=%h flags=%h expected acc=%h flags=%h",
               tag, accOut, flagsOut, expA, expF);
    end
  endtask

  task automatic apply(input logic [3:0] op, input logic [7:0] b);
    @(negedge clk);
    opValid = 1'b1; opCode = op; operand = b;
    @(negedge clk);
    opValid = 1'b0;
  endtask

  function automatic logic [7:0] pack(input bit z, input bit n, input bit h, input bit c);
    return {z, n, h, c, 4'b0000};
  endfunction

  // independent integer model for add/sub flags
  function automatic logic [15:0] arith(input logic [7:0] a, input logic [7:0] b,
                                        input bit sub, input bit cin);
    int r, hr;
    bit h, c;
    if (!sub) begin
      r = int'(a) + int'(b) + int'(cin);
      hr = int'(a & 8'h0f) + int'(b & 8'h0f) + int'(cin);
      c = (r > 255); h = (hr > 15);
    end else begin
      r = int'(a) - int'(b) - int'(cin);
      hr = int'(a & 8'h0f) - int'(b & 8'h0f) - int'(cin);
      c = (r < 0); h = (hr < 0);
    end
    return {8'(r), pack(8'(r) == 8'h00, sub, h, c)};
  endfunction

  task automatic test_reset();
    check("R1 during reset", 8'h00, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", 8'h00, 8'h00);
  endtask

  task automatic test_add();
    logic [7:0] a = 8'h1d, b = 8'h7c;
    logic [15:0] exp;
    apply(C_LDF, 8'h00); apply(C_LDA, 8'h3a);
    apply(C_ADD, 8'hc6);
    check("R2 add wrap half", 8'h00, 8'hb0);
    apply(C_ADC, 8'h00);
    check("R2 adc carry-in", 8'h01, 8'h00);
    apply(C_LDA, 8'h0f); apply(C_ADD, 8'h01);
    check("R2 half carry only", 8'h10, 8'h20);
    apply(C_LDF, 8'h10); apply(C_LDA, 8'h05); apply(C_ADD, 8'h05);
    check("R2 add ignores carry", 8'h0a, 8'h00);
    for (int i = 0; i < 24; i++) begin
      bit useC = i[0];
      bit cIn = i[1];
      apply(C_LDF, {3'b000, cIn, 4'h0}); apply(C_LDA, a);
      apply(useC ? C_ADC : C_ADD, b);
      exp = arith(a, b, 1'b0, useC & cIn);
      check("R2 sweep", exp[15:8], exp[7:0]);
      a = a * 8'd37 + 8'd11; b = {b[6:0], b[7] ^ b[5]} + 8'd3;
    end
  endtask

  task automatic test_sub();
    logic [7:0] a = 8'h93, b = 8'h28;
    logic [15:0] exp;
    apply(C_LDF, 8'h00); apply(C_LDA, 8'h10);
    apply(C_SUB, 8'h01);
    check("R3 sub half borrow", 8'h0f, 8'h60);
    apply(C_LDF, 8'h10); apply(C_LDA, 8'h00); apply(C_SBC, 8'h00);
    check("R3 sbc borrow-in wrap", 8'hff, 8'h70);
    apply(C_LDF, 8'h10); apply(C_LDA, 8'h07); apply(C_SUB, 8'h07);
    check("R3 sub ignores carry zero", 8'h00, 8'hc0);
    for (int i = 0; i < 24; i++) begin
      bit useC = i[0];
      bit cIn = i[1];
      apply(C_LDF, {3'b000, cIn, 4'h0}); apply(C_LDA, a);
      apply(useC ? C_SBC : C_SUB, b);
      exp = arith(a, b, 1'b1, useC & cIn);
      check("R3 sweep", exp[15:8], exp[7:0]);
      a = a * 8'd29 + 8'd5; b = b * 8'd13 + 8'd71;
    end
  endtask

  task automatic test_cp();
    apply(C_LDF, 8'h00); apply(C_LDA, 8'h42);
    apply(C_CP, 8'h42);
    check("R4 cp equal", 8'h42, 8'hc0);
    apply(C_CP, 8'h50);
    check("R4 cp borrow", 8'h42, 8'h50);
    apply(C_CP, 8'h03);
    check("R4 cp half borrow", 8'h42, 8'h60);
  endtask

  task automatic test_logic();
    apply(C_LDF, 8'hf0); apply(C_LDA, 8'hf0); apply(C_AND, 8'h0f);
    check("R5 and zero", 8'h00, 8'ha0);
    apply(C_LDA, 8'hf3); apply(C_AND, 8'h3c);
    check("R5 and nonzero", 8'h30, 8'h20);
    apply(C_LDF, 8'hf0); apply(C_LDA, 8'h5a); apply(C_XOR, 8'h5a);
    check("R5 xor zero", 8'h00, 8'h80);
    apply(C_LDF, 8'h70); apply(C_OR, 8'h81);
    check("R5 or", 8'h81, 8'h00);
  endtask

  task automatic test_cpl();
    apply(C_LDF, 8'h90); apply(C_LDA, 8'h35); apply(C_CPL, 8'h00);
    check("R6 cpl keep z c", 8'hca, 8'hf0);
    apply(C_LDF, 8'h00); apply(C_CPL, 8'hff);
    check("R6 cpl back", 8'h35, 8'h60);
  endtask

  task automatic test_carry_ops();
    apply(C_LDA, 8'h77); apply(C_LDF, 8'he0);
    apply(C_SCF, 8'h00);
    check("R7 scf", 8'h77, 8'h90);
    apply(C_CCF, 8'h00);
    check("R7 ccf clear", 8'h77, 8'h80);
    apply(C_LDF, 8'h60); apply(C_CCF, 8'h00);
    check("R7 ccf set", 8'h77, 8'h10);
  endtask

  task automatic test_daa();
    for (int x = 0; x < 100; x += 7) begin
      for (int y = 0; y < 100; y += 9) begin
        logic [7:0] bx = 8'((x / 10) * 16 + x % 10);
        logic [7:0] by = 8'((y / 10) * 16 + y % 10);
        int s = (x + y) % 100;
        int d = (x - y + 100) % 100;
        logic [7:0] bs = 8'((s / 10) * 16 + s % 10);
        logic [7:0] bd = 8'((d / 10) * 16 + d % 10);
        apply(C_LDF, 8'h00); apply(C_LDA, bx); apply(C_ADD, by); apply(C_DAA, 8'h00);
        check("R8 daa after add", bs, pack(bs == 8'h00, 1'b0, 1'b0, (x + y) >= 100));
        apply(C_LDF, 8'h00); apply(C_LDA, bx); apply(C_SUB, by); apply(C_DAA, 8'h00);
        check("R8 daa after sub", bd, pack(bd == 8'h00, 1'b1, 1'b0, x < y));
      end
    end
  endtask

  task automatic test_flag_byte();
    apply(C_LDA, 8'h5c);
    apply(C_LDF, 8'hff);
    check("R9 load flags low ignored", 8'h5c, 8'hf0);
    apply(C_LDF, 8'h0f);
    check("R9 low nibble only", 8'h5c, 8'h00);
    apply(C_LDF, 8'ha5);
    check("R9 bit layout", 8'h5c, 8'ha0);
  endtask

  task automatic test_load_acc();
    apply(C_LDF, 8'hb0);
    apply(C_LDA, 8'h00);
    check("R10 lda keeps flags", 8'h00, 8'hb0);
    apply(C_LDA, 8'he7);
    check("R10 lda value", 8'he7, 8'hb0);
  endtask

  task automatic test_idle();
    apply(C_LDF, 8'h50); apply(C_LDA, 8'h21);
    @(negedge clk); opValid = 1'b0; opCode = C_ADD; operand = 8'hff;
    @(negedge clk); @(negedge clk);
    check("R11 valid low holds", 8'h21, 8'h50);
    apply(4'd14, 8'hff);
    check("R11 code 14 ignored", 8'h21, 8'h50);
    apply(4'd15, 8'h00);
    check("R11 code 15 ignored", 8'h21, 8'h50);
    apply(C_SUB, 8'h01);
    check("R11 R12 next-edge result", 8'h20, 8'h40);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    test_add();
    test_sub();
    test_cp();
    test_logic();
    test_cpl();
    test_carry_ops();
    test_daa();
    test_flag_byte();
    test_load_acc();
    test_idle();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: acc=%h flags=%h expected completion", accOut, flagsOut);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule